// File: doc/BRIEF.md
# Half-Duplex Link Direction Controller

This block decides who owns a shared half-duplex link at any moment. It watches two signals: a carrier-detect flag from the demodulator and the synchronized transmit data line. From these it moves between three modes: idle, receive and transmit. It drives a direction output that steers the enable pins of an external RS-485 transceiver. It also publishes its mode and a standby flag so that the neighbouring modulator and demodulator can act on them.

Each receive or transmit episode is held open by a countdown of reference-clock cycles, which corresponds to sixteen bit times at the selected line rate. Fresh activity in the current mode reloads the countdown. Receive and transmit shut each other out: whichever mode is active blocks entry into the other until the link has gone back to idle. A two-bit rate select picks the countdown length. Its all-zero code is the slowest rate, so an unstrapped select gives the longest hold. Its all-ones code selects standby, in which the modulator is disabled and carrier detection continues.

All pins are plain control and status signals. No data stream crosses this block, so it has no valid/ready interface and no back-pressure.

Top module: `dirctl_top`

## Requirements
- R1: After reset the mode is idle (mode code 0; receive is 1, transmit is 2). In this state the direction output is low, the received-data output is high and no timer is running.
- R2: In idle, a carrier-detect of 1 at a clock edge moves the block to receive mode at that edge. Receive mode drives the direction output high.
- R3: In idle with standby not selected, transmit data at 0 at a clock edge moves the block to transmit mode at that edge. In transmit mode the direction output stays low.
- R4: While in receive mode, every cycle with carrier present reloads the timeout. The block returns to idle exactly N edges after the last edge that saw carrier.
- R5: While in transmit mode, every cycle with transmit data at 0 reloads the timeout. The block returns to idle exactly N edges after the last edge that saw transmit data low.
- R6: N is picked by rate select at each reload: code 00 gives the slowest-rate count, 01 the middle count and 10 the fastest-rate count. Code 11 (standby) uses the slowest-rate count for receive episodes.
- R7: In transmit mode, carrier on the input is ignored: the received-data output stays high and the mode stays transmit.
- R8: In receive mode, transmit data going low does not move the block to transmit mode.
- R9: If carrier and low transmit data arrive together in idle, receive mode wins.
- R10: Rate select 11 raises the standby output. In standby, low transmit data in idle does not start transmit mode, but carrier still starts receive mode.
- R11: Selecting standby while in transmit mode returns the block to idle at the next clock edge.
- R12: Outside transmit mode, the received-data output is the inverse of carrier-detect in the same cycle. It is low while carrier is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data_i | input | 1 | Synchronized transmit data, low means sending |
| rx_carrier_i | input | 1 | Carrier detected by the demodulator |
| rate_sel_i | input | 2 | Rate select: 00 slow, 01 middle, 10 fast, 11 standby |
| dir_o | output | 1 | Direction control for the external RS-485 transceiver, high in receive |
| rx_out_o | output | 1 | Received data, high when idle or transmitting |
| mode_o | output | 2 | Current mode: 0 idle, 1 receive, 2 transmit |
| standby_o | output | 1 | Standby selected, modulator disabled |

## Verification
Mode, direction and standby change at the clock edge that samples the stimulus, so they are due one edge after the inputs are driven. The received-data output follows carrier-detect combinationally in the same cycle. A timeout falls due N edges after the last edge that saw activity. The bench drives inputs on the falling edge and compares every output shortly after, against a behavioural model. The model advances on each rising edge using the same inputs, and tracks the remaining hold time as a plain integer. The bench shortens the three counts through parameters so that every rate and the exact expiry edge are exercised many times within the run.

// File: rtl/dirctl_pkg.sv
package dirctl_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_RX   = 2'd1,
    MODE_TX   = 2'd2
  } link_mode_t;

  localparam logic [1:0] RATE_SLOW    = 2'b00;
  localparam logic [1:0] RATE_MID     = 2'b01;
  localparam logic [1:0] RATE_FAST    = 2'b10;
  localparam logic [1:0] RATE_STANDBY = 2'b11;
endpackage

// File: rtl/dirctl_rate_dec.sv
module dirctl_rate_dec #(
  parameter int T_SLOW = 14507,
  parameter int T_MID  = 3630,
  parameter int T_FAST = 1192,
  parameter int CW     = 14
) (
  input  logic [1:0]    rate_sel_i,
  output logic [CW-1:0] load_o,
  output logic          standby_o
);
  import dirctl_pkg::*;

  // counter runs load..0 then expires on the following edge: N edges total
  localparam logic [CW-1:0] LOAD_SLOW = CW'(T_SLOW - 1);
  localparam logic [CW-1:0] LOAD_MID  = CW'(T_MID - 1);
  localparam logic [CW-1:0] LOAD_FAST = CW'(T_FAST - 1);

  always_comb begin
    standby_o = 1'b0;
    case (rate_sel_i)
      RATE_MID:  load_o = LOAD_MID;
      RATE_FAST: load_o = LOAD_FAST;
      RATE_STANDBY: begin
        load_o    = LOAD_SLOW;
        standby_o = 1'b1;
      end
      default:   load_o = LOAD_SLOW;
    endcase
  end
endmodule

// File: rtl/dirctl_timer.sv
module dirctl_timer #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload_i,
  input  logic [CW-1:0] load_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (reload_i)       cnt_q <= load_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dirctl_fsm.sv
module dirctl_fsm (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   carrier_i,
  input  logic                   tx_data_i,
  input  logic                   standby_i,
  input  logic                   expired_i,
  output dirctl_pkg::link_mode_t mode_o,
  output logic                   reload_o
);
  import dirctl_pkg::*;

  link_mode_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    reload_o = 1'b0;
    case (state_q)
      MODE_IDLE: begin
        if (carrier_i) begin
          state_d  = MODE_RX;
          reload_o = 1'b1;
        end else if (!tx_data_i && !standby_i) begin
          state_d  = MODE_TX;
          reload_o = 1'b1;
        end
      end
      MODE_RX: begin
        if (carrier_i)      reload_o = 1'b1;
        else if (expired_i) state_d  = MODE_IDLE;
      end
      MODE_TX: begin
        if (standby_i)       state_d  = MODE_IDLE;
        else if (!tx_data_i) reload_o = 1'b1;
        else if (expired_i)  state_d  = MODE_IDLE;
      end
      default: state_d = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MODE_IDLE;
    else        state_q <= state_d;
  end

  assign mode_o = state_q;
endmodule

// File: rtl/dirctl_top.sv
module dirctl_top #(
  parameter int T_SLOW = 14507,
  parameter int T_MID  = 3630,
  parameter int T_FAST = 1192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_data_i,
  input  logic       rx_carrier_i,
  input  logic [1:0] rate_sel_i,
  output logic       dir_o,
  output logic       rx_out_o,
  output logic [1:0] mode_o,
  output logic       standby_o
);
  import dirctl_pkg::*;

  localparam int T_MAX1 = (T_SLOW > T_MID) ? T_SLOW : T_MID;
  localparam int T_MAX  = (T_MAX1 > T_FAST) ? T_MAX1 : T_FAST;
  localparam int CW     = $clog2(T_MAX + 1);

  logic [CW-1:0] load_val;
  logic          standby;
  logic          expired;
  logic          reload;
  link_mode_t    mode;

  dirctl_rate_dec #(
    .T_SLOW(T_SLOW), .T_MID(T_MID), .T_FAST(T_FAST), .CW(CW)
  ) u_rate (
    .rate_sel_i (rate_sel_i),
    .load_o     (load_val),
    .standby_o  (standby)
  );

  dirctl_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload_i  (reload),
    .load_i    (load_val),
    .expired_o (expired)
  );

  dirctl_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .carrier_i (rx_carrier_i),
    .tx_data_i (tx_data_i),
    .standby_i (standby),
    .expired_i (expired),
    .mode_o    (mode),
    .reload_o  (reload)
  );

  assign mode_o    = mode;
  assign dir_o     = (mode == MODE_RX);
  assign rx_out_o  = !(rx_carrier_i && (mode != MODE_TX));
  assign standby_o = standby;
endmodule

// File: rtl/dirctl_checker.sv
module dirctl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_data_i,
  input logic       rx_carrier_i,
  input logic [1:0] rate_sel_i,
  input logic       dir_o,
  input logic       rx_out_o,
  input logic [1:0] mode_o,
  input logic       standby_o
);
  AST_IDLE_CARRIER_TO_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && rx_carrier_i) |=> (mode_o == 2'd1 && dir_o)); // R2
  AST_RX_HELD_BY_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && rx_carrier_i) |=> (mode_o == 2'd1)); // R4
  AST_TX_HELD_BY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && !tx_data_i && rate_sel_i != 2'b11) |=> (mode_o == 2'd2)); // R5
  AST_TX_NEVER_TO_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |=> (mode_o != 2'd1)); // R7
  AST_RX_NEVER_TO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1) |=> (mode_o != 2'd2)); // R8
  AST_STANDBY_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && standby_o && !rx_carrier_i) |=> (mode_o == 2'd0)); // R10
  AST_STANDBY_ENDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && rate_sel_i == 2'b11) |=> (mode_o == 2'd0)); // R11
endmodule

bind dirctl_top dirctl_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_data_i    (tx_data_i),
  .rx_carrier_i (rx_carrier_i),
  .rate_sel_i   (rate_sel_i),
  .dir_o        (dir_o),
  .rx_out_o     (rx_out_o),
  .mode_o       (mode_o),
  .standby_o    (standby_o)
);

// File: tb/dirctl_top_test.sv
module dirctl_top_test;
  localparam int TS = 40;
  localparam int TM = 20;
  localparam int TF = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_data = 1'b1;
  logic       carrier = 1'b0;
  logic [1:0] rate = 2'b00;
  logic       dir_o, rx_out_o, standby_o;
  logic [1:0] mode_o;

  int vectors = 0;
  int errors  = 0;
  int m_mode  = 0;
  int m_rem   = 0;
  string req  = "R1";
  bit finished = 0;

  always #10 clk = ~clk;

  dirctl_top #(.T_SLOW(TS), .T_MID(TM), .T_FAST(TF)) uut (
    .clk(clk), .rst_n(rst_n), .tx_data_i(tx_data), .rx_carrier_i(carrier),
    .rate_sel_i(rate), .dir_o(dir_o), .rx_out_o(rx_out_o), .mode_o(mode_o),
    .standby_o(standby_o)
  );

  function automatic int hold_len(input logic [1:0] r);
    case (r)
      2'b01:   return TM;
      2'b10:   return TF;
      default: return TS;
    endcase
  endfunction

  task automatic compare();
    int e_dir = (m_mode == 1) ? 1 : 0;
    int e_rx  = (carrier && m_mode != 2) ? 0 : 1;
    int e_sb  = (rate == 2'b11) ? 1 : 0;
    vectors++;
    if (int'(mode_o) != m_mode || int'(dir_o) != e_dir ||
        int'(rx_out_o) != e_rx || int'(standby_o) != e_sb) begin
      errors++;
      $display("FAIL %s t=%0t mode/dir/rx/sb got %0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d",
               req, $time, mode_o, dir_o, rx_out_o, standby_o,
               m_mode, e_dir, e_rx, e_sb);
    end
  endtask

  task automatic model_edge();
    case (m_mode)
      0: if (carrier) begin m_mode = 1; m_rem = hold_len(rate); end
         else if (!tx_data && rate != 2'b11) begin m_mode = 2; m_rem = hold_len(rate); end
      1: if (carrier) m_rem = hold_len(rate);
         else begin m_rem--; if (m_rem == 0) m_mode = 0; end
      default:
         if (rate == 2'b11) m_mode = 0;
         else if (!tx_data) m_rem = hold_len(rate);
         else begin m_rem--; if (m_rem == 0) m_mode = 0; end
    endcase
  endtask

  task automatic step(input int n, input logic car, input logic tx, input logic [1:0] r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      carrier = car; tx_data = tx; rate = r;
      #1 compare();
      @(posedge clk);
      model_edge();
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    req = "R1";
    #1 compare();
    @(posedge clk);
    model_edge();
    // R2 R4 R12: receive entry, reload by carrier, exact expiry at slow rate
    req = "R2_R4_R12";
    step(5, 1, 1, 2'b00);
    step(10, 0, 1, 2'b00);
    step(3, 1, 1, 2'b00);
    // R8: transmit data low during receive is not honoured
    req = "R8";
    step(4, 0, 0, 2'b00);
    req = "R4";
    step(TS + 5, 0, 1, 2'b00);
    // R3 R5 R6: transmit at middle rate with reload
    req = "R3_R5_R6";
    step(4, 0, 0, 2'b01);
    step(8, 0, 1, 2'b01);
    step(2, 0, 0, 2'b01);
    // R7: carrier ignored while transmitting
    req = "R7";
    step(5, 1, 1, 2'b01);
    req = "R5";
    step(TM + 4, 0, 1, 2'b01);
    // R6: fast rate, transmit and receive
    req = "R6";
    step(1, 0, 0, 2'b10);
    step(TF + 3, 0, 1, 2'b10);
    step(2, 1, 1, 2'b10);
    step(TF + 3, 0, 1, 2'b10);
    // R9: simultaneous activity in idle
    req = "R9";
    step(2, 1, 0, 2'b00);
    step(TS + 3, 0, 1, 2'b00);
    // R10: standby blocks transmit, allows receive with slow hold
    req = "R10";
    step(10, 0, 0, 2'b11);
    step(2, 1, 1, 2'b11);
    step(TS + 3, 0, 1, 2'b11);
    // R11: standby during transmit ends it
    req = "R11";
    step(3, 0, 0, 2'b00);
    step(5, 0, 1, 2'b11);
    step(3, 0, 1, 2'b00);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule